// File: doc/BRIEF.md
# Subaddress Data Tag Word Tracker

This block keeps one status tag word for every receive buffer and every transmit buffer of a command/response serial bus remote terminal. There are 32 of each, and a buffer is picked by a direction bit and a 5-bit subaddress. The message engine reports four kinds of event: a receive begins, a receive completes (with a broadcast flag), a receive is aborted, and a transmit buffer is sent. The host reports that it has read a receive buffer. From these events each tag tracks five things: whether the data is valid, whether it is fresh (updated since last read), whether a receive is writing into it now, whether the last data came by broadcast, and whether unread data was overwritten.

A small receive sequencer with two states follows each receive message. In `RX_IDLE`, a start strobe latches the subaddress and moves the sequencer to `RX_FILL`. In `RX_FILL`, a completion or an abort commits or drops the update and returns it to `RX_IDLE`. When the host enables it, the block raises a one-cycle subsystem-flag request when stale transmit data is sent or when fresh unread receive data is overwritten. The host reads any tag through a combinational register port and can rewrite the valid and fresh bits of any tag.

Top module: `tagtrk_top`

## Requirements
- R1: After reset every tag reads 0, `rx_active` is 0 and `sflag_req` is 0.
- R2: `host_rdata` shows the tag selected by `host_addr` in the same cycle. Bit 5 of the address is the direction (0 receive, 1 transmit) and bits 4:0 are the subaddress. Tag bits are: 0 valid, 1 fresh, 2 busy (update in progress), 3 broadcast, 4 lost.
- R3: When `rx_start` is high in RX_IDLE, the sequencer latches `rx_sa`, moves to RX_FILL (`rx_active` = 1) and sets the busy bit of that receive tag after the edge. A start seen in RX_FILL is ignored.
- R4: When `rx_done` is high in RX_FILL, the latched tag gets valid=1, fresh=1, busy=0 and broadcast=`rx_bcast`, and the sequencer returns to RX_IDLE. Done or abort strobes seen in RX_IDLE have no effect.
- R5: When `rx_abort` is high in RX_FILL, the busy bit clears and the sequencer returns to RX_IDLE. Valid, fresh, broadcast and lost are left unchanged. If done and abort arrive together, done wins.
- R6: `ack_go` clears the fresh bit of the receive tag at `ack_sa`.
- R7: A completion into a tag that is still fresh sets its lost bit, unless an acknowledge for that tag arrives in the same cycle. In that case the tag ends fresh and lost is not set. The lost bit stays set until a host write clears it.
- R8: `tx_go` clears the fresh bit of the transmit tag at `tx_sa`.
- R9: When `cfg_sflag_en` is 1, `sflag_req` is high for exactly the one cycle after an overwrite (R7 lost condition) or after a transmit of a tag whose fresh bit is 0. When `cfg_sflag_en` is 0 it stays low.
- R10: `host_wr` loads valid and fresh from `host_wdata` bits 0 and 1, clears broadcast and lost, and keeps busy. The write is ignored if the tag is busy or if an engine event (start, done, abort, transmit) hits the same tag in that cycle. The write takes precedence over an acknowledge to the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sflag_en | input | 1 | Enables the subsystem-flag request |
| rx_start | input | 1 | Receive message begins for `rx_sa` |
| rx_done | input | 1 | Receive message completed |
| rx_abort | input | 1 | Receive message abandoned |
| rx_sa | input | 5 | Receive subaddress, sampled with `rx_start` |
| rx_bcast | input | 1 | Completed receive was a broadcast |
| tx_go | input | 1 | Transmit buffer `tx_sa` was sent |
| tx_sa | input | 5 | Transmit subaddress |
| ack_go | input | 1 | Host has read receive buffer `ack_sa` |
| ack_sa | input | 5 | Acknowledged receive subaddress |
| host_wr | input | 1 | Host tag write strobe |
| host_addr | input | 6 | Tag select {direction, subaddress} |
| host_wdata | input | 5 | Host write data |
| host_rdata | output | 5 | Selected tag word |
| rx_active | output | 1 | Sequencer is in RX_FILL |
| sflag_req | output | 1 | Subsystem-flag request pulse |

## Verification
The bench builds the block with the default of 32 subaddresses per direction, so the full 6-bit host address space is decoded. It draws the random subaddresses mostly from a cluster of four plus the top index, 31. That clustering makes collisions common: acknowledge with completion, write with transmit, write with a busy tag. It also exercises the highest decode. A behavioural model of every tag is compared with the read port, `rx_active` and `sflag_req` on every cycle, and directed sequences before the random run cover each requirement.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;

    localparam int TAG_W   = 5;
    localparam int B_VALID = 0;
    localparam int B_FRESH = 1;

    typedef struct packed {
        logic lost;
        logic bcast;
        logic busy;
        logic fresh;
        logic valid;
    } tag_t;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;

endpackage

// File: rtl/tagtrk_rxseq.sv
module tagtrk_rxseq
    import tagtrk_pkg::*;
#(
    parameter int SA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_start,
    input  logic            rx_done,
    input  logic            rx_abort,
    input  logic [SA_W-1:0] rx_sa,
    output logic            st_stb,
    output logic            dn_stb,
    output logic            ab_stb,
    output logic [SA_W-1:0] cur_sa,
    output logic            rx_active
);

    rx_state_e       state_q, state_d;
    logic [SA_W-1:0] sa_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sa_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_IDLE && rx_start) sa_q <= rx_sa;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rx_start) state_d = RX_FILL;
            RX_FILL: if (rx_done || rx_abort) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        st_stb    = 1'b0;
        dn_stb    = 1'b0;
        ab_stb    = 1'b0;
        cur_sa    = sa_q;
        rx_active = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                st_stb = rx_start;
                cur_sa = rx_sa;
            end
            RX_FILL: begin
                rx_active = 1'b1;
                dn_stb    = rx_done;
                ab_stb    = rx_abort && !rx_done;
            end
            default: ;
        endcase
    end

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_stb, dn_stb, ab_stb}));

    // R4
    done_leaves_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stb || ab_stb) |=> !rx_active);

    // R3
    start_enters_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_stb |=> rx_active);

endmodule

// File: rtl/tagtrk_cell.sv
module tagtrk_cell
    import tagtrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_hit,
    input  logic             dn_hit,
    input  logic             ab_hit,
    input  logic             tx_hit,
    input  logic             ack_hit,
    input  logic             wr_hit,
    input  logic             bcast_in,
    input  logic [TAG_W-1:0] wdata,
    output tag_t             tag_q,
    output logic             ovw,
    output logic             stale
);

    tag_t tag_d;
    logic eng_evt;
    logic wr_acc;
    logic ack_eff;

    always_comb begin
        eng_evt = st_hit | dn_hit | ab_hit | tx_hit;
        wr_acc  = wr_hit & ~tag_q.busy & ~eng_evt;
        ack_eff = ack_hit & ~wr_acc;
        ovw     = dn_hit & tag_q.fresh & ~ack_eff;
        stale   = tx_hit & ~tag_q.fresh;

        tag_d = tag_q;
        if (wr_acc) begin
            tag_d.valid = wdata[B_VALID];
            tag_d.fresh = wdata[B_FRESH];
            tag_d.bcast = 1'b0;
            tag_d.lost  = 1'b0;
        end
        if (ack_eff) tag_d.fresh = 1'b0;
        if (st_hit)  tag_d.busy  = 1'b1;
        if (ab_hit)  tag_d.busy  = 1'b0;
        if (dn_hit) begin
            tag_d.lost  = tag_q.lost | ovw;
            tag_d.valid = 1'b1;
            tag_d.fresh = 1'b1;
            tag_d.busy  = 1'b0;
            tag_d.bcast = bcast_in;
        end
        if (tx_hit) tag_d.fresh = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    // R4
    done_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_hit |=> (tag_q.valid && tag_q.fresh && !tag_q.busy));

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_q.busy) |-> $past(st_hit));

    // R7
    lost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_q.lost) |-> $past(dn_hit));

    // R5
    abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_hit && !dn_hit) |=> (!tag_q.busy && $stable(tag_q.valid)));

    // R8
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> !tag_q.fresh);

endmodule

// File: rtl/tagtrk_sflag.sv
module tagtrk_sflag #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic [N-1:0] ovw_vec,
    input  logic [N-1:0] stale_vec,
    output logic         sflag_req
);

    logic any_evt;

    always_comb any_evt = (|ovw_vec) | (|stale_vec);

    always_ff @(posedge clk) begin
        if (!rst_n) sflag_req <= 1'b0;
        else        sflag_req <= cfg_en & any_evt;
    end

    // R9
    sflag_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sflag_req |-> $past(cfg_en));

    // R9
    sflag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sflag_req |-> $past(|(ovw_vec | stale_vec)));

endmodule

// File: rtl/tagtrk_top.sv
module tagtrk_top
    import tagtrk_pkg::*;
#(
    parameter int NUM_SA = 32,
    parameter int SA_W   = $clog2(NUM_SA),
    parameter int IDX_W  = SA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sflag_en,
    input  logic             rx_start,
    input  logic             rx_done,
    input  logic             rx_abort,
    input  logic [SA_W-1:0]  rx_sa,
    input  logic             rx_bcast,
    input  logic             tx_go,
    input  logic [SA_W-1:0]  tx_sa,
    input  logic             ack_go,
    input  logic [SA_W-1:0]  ack_sa,
    input  logic             host_wr,
    input  logic [IDX_W-1:0] host_addr,
    input  logic [TAG_W-1:0] host_wdata,
    output logic [TAG_W-1:0] host_rdata,
    output logic             rx_active,
    output logic             sflag_req
);

    localparam int NT = 2 * NUM_SA;

    logic            st_stb, dn_stb, ab_stb;
    logic [SA_W-1:0] cur_sa;
    logic [TAG_W-1:0] tag_arr [NT];
    logic [NT-1:0]   ovw_vec;
    logic [NT-1:0]   stale_vec;

    tagtrk_rxseq #(.SA_W(SA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_start  (rx_start),
        .rx_done   (rx_done),
        .rx_abort  (rx_abort),
        .rx_sa     (rx_sa),
        .st_stb    (st_stb),
        .dn_stb    (dn_stb),
        .ab_stb    (ab_stb),
        .cur_sa    (cur_sa),
        .rx_active (rx_active)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tag
        tag_t cell_q;
        logic wr_hit;
        assign wr_hit     = host_wr && (host_addr == IDX_W'(i));
        assign tag_arr[i] = cell_q;

        if (i < NUM_SA) begin : g_rx
            logic sel;
            assign sel = (cur_sa == SA_W'(i));
            tagtrk_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .st_hit   (st_stb && sel),
                .dn_hit   (dn_stb && sel),
                .ab_hit   (ab_stb && sel),
                .tx_hit   (1'b0),
                .ack_hit  (ack_go && (ack_sa == SA_W'(i))),
                .wr_hit   (wr_hit),
                .bcast_in (rx_bcast),
                .wdata    (host_wdata),
                .tag_q    (cell_q),
                .ovw      (ovw_vec[i]),
                .stale    (stale_vec[i])
            );
        end else begin : g_tx
            tagtrk_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .st_hit   (1'b0),
                .dn_hit   (1'b0),
                .ab_hit   (1'b0),
                .tx_hit   (tx_go && (tx_sa == SA_W'(i - NUM_SA))),
                .ack_hit  (1'b0),
                .wr_hit   (wr_hit),
                .bcast_in (1'b0),
                .wdata    (host_wdata),
                .tag_q    (cell_q),
                .ovw      (ovw_vec[i]),
                .stale    (stale_vec[i])
            );
        end
    end

    always_comb host_rdata = tag_arr[host_addr];

    tagtrk_sflag #(.N(NT)) u_sflag (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_sflag_en),
        .ovw_vec   (ovw_vec),
        .stale_vec (stale_vec),
        .sflag_req (sflag_req)
    );

endmodule

// File: tb/tb_tagtrk_top.sv
module tb_tagtrk_top;

    localparam int NSA = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sflag_en = 1'b1;
    logic       rx_start = 0, rx_done = 0, rx_abort = 0, rx_bcast = 0;
    logic [4:0] rx_sa = 0;
    logic       tx_go = 0;
    logic [4:0] tx_sa = 0;
    logic       ack_go = 0;
    logic [4:0] ack_sa = 0;
    logic       host_wr = 0;
    logic [5:0] host_addr = 0;
    logic [4:0] host_wdata = 0;
    logic [4:0] host_rdata;
    logic       rx_active;
    logic       sflag_req;

    always #2 clk = ~clk;

    tagtrk_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_sflag_en(cfg_sflag_en),
        .rx_start(rx_start), .rx_done(rx_done), .rx_abort(rx_abort),
        .rx_sa(rx_sa), .rx_bcast(rx_bcast), .tx_go(tx_go), .tx_sa(tx_sa),
        .ack_go(ack_go), .ack_sa(ack_sa), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_active(rx_active), .sflag_req(sflag_req)
    );

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    bit m_valid[64], m_fresh[64], m_busy[64], m_bc[64], m_lost[64];
    bit m_fill = 0;
    int m_sa = 0;
    bit m_sflag = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int mtag(int i);
        return m_valid[i] + 2*m_fresh[i] + 4*m_busy[i] + 8*m_bc[i] + 16*m_lost[i];
    endfunction

    task automatic model_step();
        bit st, dn, ab, eng, wacc, ackeff, ovw, stale, fr_ri, fr_tx;
        int ri, txi, wi, ai;
        st  = rx_start && !m_fill;
        dn  = m_fill && rx_done;
        ab  = m_fill && rx_abort && !rx_done;
        ri  = st ? int'(rx_sa) : m_sa;
        txi = NSA + int'(tx_sa);
        wi  = int'(host_addr);
        ai  = int'(ack_sa);
        eng = ((st || dn || ab) && ri == wi) || (tx_go && txi == wi);
        wacc = host_wr && !m_busy[wi] && !eng;
        ackeff = ack_go && !(wacc && wi == ai);
        fr_ri = m_fresh[ri];
        fr_tx = m_fresh[txi];
        ovw = 0;
        stale = 0;
        if (wacc) begin
            m_valid[wi] = host_wdata[0];
            m_fresh[wi] = host_wdata[1];
            m_bc[wi] = 0;
            m_lost[wi] = 0;
        end
        if (ackeff) m_fresh[ai] = 0;
        if (st) m_busy[ri] = 1;
        if (ab) m_busy[ri] = 0;
        if (dn) begin
            ovw = fr_ri && !(ackeff && ai == ri);
            m_lost[ri] = m_lost[ri] | ovw;
            m_valid[ri] = 1;
            m_fresh[ri] = 1;
            m_busy[ri] = 0;
            m_bc[ri] = rx_bcast;
        end
        if (tx_go) begin
            stale = !fr_tx;
            m_fresh[txi] = 0;
        end
        if (st) begin m_fill = 1; m_sa = int'(rx_sa); end
        else if (dn || ab) m_fill = 0;
        m_sflag = cfg_sflag_en && (ovw || stale);
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        chk("R2 model tag", int'(host_rdata), mtag(int'(host_addr)));
        chk("R3 model rx_active", int'(rx_active), int'(m_fill));
        chk("R9 model sflag_req", int'(sflag_req), int'(m_sflag));
        rx_start = 0; rx_done = 0; rx_abort = 0; tx_go = 0;
        ack_go = 0; host_wr = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 rdata rx0", int'(host_rdata), 0);
        host_addr = 6'd63;
        #1 chk("R1 rdata tx31", int'(host_rdata), 0);
        chk("R1 rx_active", int'(rx_active), 0);
        chk("R1 sflag_req", int'(sflag_req), 0);

        // R3: start sets busy
        host_addr = 6'd3; rx_sa = 5'd3; rx_start = 1; cyc();
        chk("R3 busy set", int'(host_rdata), 4);
        chk("R3 rx_active", int'(rx_active), 1);
        // R3: start while filling ignored
        host_addr = 6'd5; rx_sa = 5'd5; rx_start = 1; cyc();
        chk("R3 start ignored", int'(host_rdata), 0);
        // R4: done with broadcast
        host_addr = 6'd3; rx_done = 1; rx_bcast = 1; cyc();
        chk("R4 commit", int'(host_rdata), 11);
        chk("R4 back idle", int'(rx_active), 0);
        // R4: done in idle ignored
        rx_done = 1; rx_bcast = 0; cyc();
        chk("R4 idle done ignored", int'(host_rdata), 11);
        // R7/R9: overwrite of fresh data
        rx_sa = 5'd3; rx_start = 1; cyc();
        chk("R3 busy again", int'(host_rdata), 15);
        rx_done = 1; rx_bcast = 0; cyc();
        chk("R7 lost set", int'(host_rdata), 19);
        chk("R9 sflag overwrite", int'(sflag_req), 1);
        // R6: ack clears fresh
        ack_sa = 5'd3; ack_go = 1; cyc();
        chk("R6 ack", int'(host_rdata), 17);
        chk("R9 pulse one cycle", int'(sflag_req), 0);
        // R5: abort keeps data
        rx_sa = 5'd3; rx_start = 1; cyc();
        rx_abort = 1; cyc();
        chk("R5 abort", int'(host_rdata), 17);
        // R5: done beats abort
        rx_start = 1; cyc();
        rx_done = 1; rx_abort = 1; cyc();
        chk("R5 done wins", int'(host_rdata), 19);
        chk("R9 no flag on fresh-0 done", int'(sflag_req), 0);
        // R10: write clears lost and bcast
        host_wr = 1; host_wdata = 5'd3; cyc();
        chk("R10 write", int'(host_rdata), 3);
        // R7: ack and done same cycle
        rx_start = 1; cyc();
        rx_done = 1; ack_go = 1; ack_sa = 5'd3; cyc();
        chk("R7 ack+done", int'(host_rdata), 3);
        chk("R7 no flag", int'(sflag_req), 0);
        // R8/R9: transmit
        host_addr = 6'd34; host_wr = 1; host_wdata = 5'd3; cyc();
        chk("R10 tx write", int'(host_rdata), 3);
        tx_sa = 5'd2; tx_go = 1; cyc();
        chk("R8 tx clears fresh", int'(host_rdata), 1);
        chk("R9 fresh tx no flag", int'(sflag_req), 0);
        tx_go = 1; cyc();
        chk("R9 stale tx flag", int'(sflag_req), 1);
        cfg_sflag_en = 0; tx_go = 1; cyc();
        chk("R9 disabled", int'(sflag_req), 0);
        cfg_sflag_en = 1;
        // R10: write to busy tag ignored
        host_addr = 6'd4; rx_sa = 5'd4; rx_start = 1; cyc();
        host_wr = 1; host_wdata = 5'd3; cyc();
        chk("R10 busy write ignored", int'(host_rdata), 4);
        rx_done = 1; cyc();
        chk("R4 commit sa4", int'(host_rdata), 3);
        // R10: write beats ack
        host_wr = 1; host_wdata = 5'd3; ack_go = 1; ack_sa = 5'd4; cyc();
        chk("R10 write over ack", int'(host_rdata), 3);
        // R10: write vs transmit same tag
        host_addr = 6'd63; host_wr = 1; host_wdata = 5'd3; cyc();
        host_wr = 1; host_wdata = 5'd1; tx_sa = 5'd31; tx_go = 1; cyc();
        chk("R10 tx beats write", int'(host_rdata), 1);

        // random phase, model compared every cycle
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = int'($urandom % 8);
            rx_sa     = (r == 7) ? 5'd31 : 5'($urandom % 4);
            tx_sa     = ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 4);
            ack_sa    = ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 4);
            host_addr = {1'($urandom % 2), (($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 4))};
            host_wdata = 5'($urandom);
            rx_start  = ($urandom % 4 == 0);
            rx_done   = ($urandom % 4 == 0);
            rx_abort  = ($urandom % 8 == 0);
            rx_bcast  = 1'($urandom % 2);
            tx_go     = ($urandom % 4 == 0);
            ack_go    = ($urandom % 4 == 0);
            host_wr   = ($urandom % 5 == 0);
            cfg_sflag_en = ($urandom % 8 != 0);
            cyc();
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule